// File: doc/BRIEF.md
# Receive Word Queue with Fill-Level Interrupts

This block sits behind the bit-recovery stage of a serial receiver. Each time the deserializer finishes a character it pulses a strobe with up to nine data bits and two error tags: a parity fault and a framing fault. The word first lands in a single holding stage. From there it moves into a four-entry first-in first-out store, so up to five words can wait before software must act.

Software pops words with a read strobe and always sees the head word and its tags on the output. A level flag shows whether the store holds anything. An interrupt pulse is raised on transfers into the store. A 2-bit select chooses whether every transfer raises it, only the one that brings the store to three words, or only the one that fills it.

When a sixth word arrives with the store full and the holding stage occupied, a sticky overrun flag rises and reception freezes. The stored words stay readable. Clearing the flag drops the held word and resumes reception.

Top module: `rx_word_queue`

## Requirements
- R1: With no reads, five back-to-back words are all kept (four in the store, one in the holding stage) and the overrun flag stays 0.
- R2: `avail` is 1 exactly when the store holds one or more words; a word waiting only in the holding stage does not count.
- R3: A read while the store is empty leaves `rd_data`, `rd_perr`, `rd_ferr` and `avail` unchanged, and moves nothing.
- R4: A word strobed at clock edge k enters the holding stage at edge k, moves to the store at edge k+1 if there is room, and is visible at the outputs after k+1. A read pops the head word, and after that edge the outputs show the next word with its own tags. After the last word is popped, the outputs keep showing the popped word.
- R5: With `irq_sel` = 00 or 01, `irq` is high for one cycle after every holding-to-store transfer.
- R6: With `irq_sel` = 10, `irq` pulses only after a transfer that raises the store from 2 to 3 words, meaning no read is popped in the same cycle.
- R7: With `irq_sel` = 11, `irq` pulses only after a transfer that raises the store from 3 to 4 words (full), with no pop in the same cycle.
- R8: A word strobed while the store is full and the holding stage is occupied sets `ovr` on that edge, and the new word is dropped.
- R9: While `ovr` is 1, the flag stays set until it is cleared, strobed words are ignored, and the held word is not transferred. Words already in the store stay readable in order.
- R10: Pulsing `ovr_clr` while `ovr` is 1 clears `ovr` on that edge and discards the held word. A word strobed afterwards is received normally.
- R11: After synchronous reset the store is empty: `avail`, `ovr` and `irq` are 0, and `rd_data`, `rd_perr` and `rd_ferr` are 0.
- R12: When a read frees a slot in a full store while a word is held and `ovr` is 0, the held word moves in on the following edge, and that transfer is judged for the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wd_valid | input | 1 | Word-complete strobe from the deserializer |
| wd_data | input | 9 | Completed word |
| wd_perr | input | 1 | Parity-fault tag of the completed word |
| wd_ferr | input | 1 | Framing-fault tag of the completed word |
| rd_en | input | 1 | Pop the head word |
| rd_data | output | 9 | Head word, or last popped word when empty |
| rd_perr | output | 1 | Parity-fault tag belonging to `rd_data` |
| rd_ferr | output | 1 | Framing-fault tag belonging to `rd_data` |
| avail | output | 1 | Store holds at least one word |
| irq_sel | input | 2 | Interrupt mode: 0x every transfer, 10 count reaches 3, 11 count reaches 4 |
| irq | output | 1 | One-cycle interrupt pulse |
| ovr | output | 1 | Sticky overrun flag |
| ovr_clr | input | 1 | Clears `ovr` and drops the held word |

## Verification
A pop by software and a holding-to-store transfer can land on the same clock edge. This changes both the head word and whether a threshold interrupt counts as reached. A second collision is an overrun clear and a new strobe in the same cycle. The bench provokes both through long stretches of random strobes, reads, clears and mode changes, with the store kept near full. A queue-based reference model predicts the head word, tags, level flag, overrun flag and interrupt pulse, and these are compared every cycle. Directed sequences pin the exact threshold counts and the freeze-and-clear behaviour.

// File: rtl/rx_word_queue_pkg.sv
// Shared types for the receive word queue.
// Assumes a nine-bit maximum word; narrower words are zero-extended by the source.
package rx_word_queue_pkg;

    localparam int unsigned WORD_W = 9;

    // One stored character with its error tags
    typedef struct packed {
        logic              perr;
        logic              ferr;
        logic [WORD_W-1:0] data;
    } rxq_entry_t;

    // Interrupt threshold modes
    typedef enum logic [1:0] {
        IRQ_EACH_A  = 2'b00,
        IRQ_EACH_B  = 2'b01,
        IRQ_AT_MID  = 2'b10,
        IRQ_AT_FULL = 2'b11
    } irq_mode_e;

endpackage

// File: rtl/rxq_holding.sv
// Holding stage between the deserializer and the store.
// It acts as the fifth buffer slot and owns the sticky overrun flag.
// Assumes fifo_full is the registered full level of the store.
module rxq_holding
    import rx_word_queue_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       word_stb,
    input  rxq_entry_t word_in,
    input  logic       fifo_full,
    input  logic       ovr_clr,
    output logic       pend_vld,
    output rxq_entry_t pend_word,
    output logic       xfer,
    output logic       ovr
);

    logic accept;
    logic overrun_hit;

    // Move the held word when the store has room and reception is live
    assign xfer        = pend_vld && !fifo_full && !ovr;
    // Take a new word when the stage is empty or emptying this cycle
    assign accept      = word_stb && !ovr && (!pend_vld || xfer);
    // A new word with nowhere to go is an overrun
    assign overrun_hit = word_stb && !ovr && pend_vld && !xfer;

    // Holding register and overrun flag update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld  <= 1'b0;
            pend_word <= '0;
            ovr       <= 1'b0;
        end else if (ovr) begin
            if (ovr_clr) begin
                ovr      <= 1'b0;
                pend_vld <= 1'b0;
            end
        end else if (accept) begin
            pend_vld  <= 1'b1;
            pend_word <= word_in;
        end else if (overrun_hit) begin
            ovr <= 1'b1;
        end else if (xfer) begin
            pend_vld <= 1'b0;
        end
    end

endmodule

// File: rtl/rxq_store.sv
// Circular store of DEPTH entries with an output that holds the last popped word.
// Assumes push is never asserted while full; it is cleared only by reset.
module rxq_store
    import rx_word_queue_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  rxq_entry_t                     push_word,
    input  logic                           pop_req,
    output rxq_entry_t                     head_word,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           avail,
    output logic                           full,
    output logic                           pop
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    rxq_entry_t       last_q;
    rxq_entry_t       mem [DEPTH];

    assign avail = (count != '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign pop   = pop_req && avail;

    // One register per slot, written when the write pointer selects it
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        rxq_entry_t slot_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (push && (wr_ptr == PTR_W'(s))) begin
                slot_q <= push_word;
            end
        end
        assign mem[s] = slot_q;
    end

    // Pointer, level and last-popped bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            last_q <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
                last_q <= mem[rd_ptr];
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Head word when occupied, otherwise the word most recently popped
    always_comb begin
        head_word = avail ? mem[rd_ptr] : last_q;
    end

endmodule

// File: rtl/rxq_irq.sv
// Interrupt pulse generator judging each transfer against the selected threshold.
// Assumes count is the store level before the current edge.
module rxq_irq
    import rx_word_queue_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       xfer,
    input  logic                       pop,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic [1:0]                 irq_sel,
    output logic                       irq
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    irq_mode_e mode;
    logic      hit;

    assign mode = irq_mode_e'(irq_sel);

    // Decide whether this transfer meets the selected condition
    always_comb begin
        case (mode)
            IRQ_AT_MID:  hit = xfer && !pop && (count == CNT_W'(DEPTH - 2));
            IRQ_AT_FULL: hit = xfer && !pop && (count == CNT_W'(DEPTH - 1));
            default:     hit = xfer;
        endcase
    end

    // Register the decision as a one-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= hit;
        end
    end

endmodule

// File: rtl/rx_word_queue.sv
// Receive word queue: holding stage, DEPTH-entry store and threshold interrupt.
// Assumes wd_valid is a single-cycle strobe per completed character.
module rx_word_queue
    import rx_word_queue_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wd_valid,
    input  logic [WORD_W-1:0] wd_data,
    input  logic              wd_perr,
    input  logic              wd_ferr,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_perr,
    output logic              rd_ferr,
    output logic              avail,
    input  logic [1:0]        irq_sel,
    output logic              irq,
    output logic              ovr,
    input  logic              ovr_clr
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    rxq_entry_t       word_in;
    rxq_entry_t       pend_word;
    rxq_entry_t       head_word;
    logic             pend_vld;
    logic             xfer;
    logic             full;
    logic             pop;
    logic [CNT_W-1:0] count;

    assign word_in = '{perr: wd_perr, ferr: wd_ferr, data: wd_data};

    rxq_holding u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_stb  (wd_valid),
        .word_in   (word_in),
        .fifo_full (full),
        .ovr_clr   (ovr_clr),
        .pend_vld  (pend_vld),
        .pend_word (pend_word),
        .xfer      (xfer),
        .ovr       (ovr)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (xfer),
        .push_word (pend_word),
        .pop_req   (rd_en),
        .head_word (head_word),
        .count     (count),
        .avail     (avail),
        .full      (full),
        .pop       (pop)
    );

    rxq_irq #(.DEPTH(DEPTH)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .xfer    (xfer),
        .pop     (pop),
        .count   (count),
        .irq_sel (irq_sel),
        .irq     (irq)
    );

    assign rd_data = head_word.data;
    assign rd_perr = head_word.perr;
    assign rd_ferr = head_word.ferr;

endmodule

// File: rtl/rx_word_queue_chk.sv
// Temporal checks on the receive word queue, attached by bind.
// Assumes the top-level signal names used in the bind below.
module rx_word_queue_chk
    import rx_word_queue_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wd_valid,
    input logic                       rd_en,
    input logic                       avail,
    input logic                       ovr,
    input logic                       ovr_clr,
    input logic                       irq,
    input logic [WORD_W-1:0]          rd_data,
    input logic [$clog2(DEPTH+1)-1:0] count,
    input logic                       full,
    input logic                       xfer
);

    // R1: level never exceeds the store depth
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= ($clog2(DEPTH+1))'(DEPTH));

    // R2: an empty store with no transfer stays empty across a read
    p_empty_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!avail && !xfer) |=> !avail);

    // R3: reading an empty store leaves the output word alone
    p_empty_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!avail && rd_en && !xfer) |=> $stable(rd_data));

    // R5: every interrupt pulse follows a transfer
    p_irq_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(xfer));

    // R8: overrun only rises after a strobe into a full store
    p_ovr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> ($past(wd_valid) && $past(full)));

    // R9: overrun is sticky until cleared
    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr) |=> ovr);

    // R9: no word enters the store while overrun is set
    p_no_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> (count <= $past(count)));

    // R10: a clear drops the flag on the next edge
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && ovr_clr) |=> !ovr);

endmodule

bind rx_word_queue rx_word_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wd_valid (wd_valid),
    .rd_en    (rd_en),
    .avail    (avail),
    .ovr      (ovr),
    .ovr_clr  (ovr_clr),
    .irq      (irq),
    .rd_data  (rd_data),
    .count    (count),
    .full     (full),
    .xfer     (xfer)
);

// File: tb/rx_word_queue_tb.sv
// Self-checking bench: queue-based reference model compared every cycle, plus directed cases.
module rx_word_queue_tb;

    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wd_valid = 1'b0;
    logic [8:0] wd_data = '0;
    logic       wd_perr = 1'b0;
    logic       wd_ferr = 1'b0;
    logic       rd_en = 1'b0;
    logic [8:0] rd_data;
    logic       rd_perr;
    logic       rd_ferr;
    logic       avail;
    logic [1:0] irq_sel = 2'b00;
    logic       irq;
    logic       ovr;
    logic       ovr_clr = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int irq_seen = 0;
    bit done = 0;

    // Reference model state: entries are {perr, ferr, data}
    logic [10:0] q[$];
    logic [10:0] hold_e;
    logic [10:0] last_e;
    bit          hold_v;
    bit          m_ovr;
    bit          m_irq;
    int          cnt;
    bit          m_pop;
    bit          m_xf;
    bit          thr_ok;

    always #10 clk = ~clk;

    rx_word_queue #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wd_valid(wd_valid), .wd_data(wd_data),
        .wd_perr(wd_perr), .wd_ferr(wd_ferr), .rd_en(rd_en), .rd_data(rd_data),
        .rd_perr(rd_perr), .rd_ferr(rd_ferr), .avail(avail), .irq_sel(irq_sel),
        .irq(irq), .ovr(ovr), .ovr_clr(ovr_clr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [10:0] w(input int i);
        return {i[0], i[1] ^ i[2], 9'(i * 37 + 5)};
    endfunction

    // Reference model update at each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            hold_v = 0; hold_e = '0; m_ovr = 0; last_e = '0; m_irq = 0;
        end else begin
            cnt    = q.size();
            m_pop  = rd_en && cnt > 0;
            m_xf   = hold_v && cnt < DEPTH && !m_ovr;
            thr_ok = (irq_sel[1] == 1'b0) ? 1'b1 :
                     (!m_pop && cnt == (irq_sel[0] ? DEPTH - 1 : DEPTH - 2));
            m_irq  = m_xf && thr_ok;
            if (m_pop) last_e = q.pop_front();
            if (m_xf) q.push_back(hold_e);
            if (m_ovr) begin
                if (ovr_clr) begin m_ovr = 0; hold_v = 0; end
            end else if (wd_valid && (!hold_v || m_xf)) begin
                hold_v = 1; hold_e = {wd_perr, wd_ferr, wd_data};
            end else if (wd_valid) begin
                m_ovr = 1;
            end else if (m_xf) begin
                hold_v = 0;
            end
        end
    end

    // Count interrupt pulses
    always @(posedge clk) if (rst_n && irq) irq_seen++;

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 avail vs model", avail, q.size() > 0);
            if (q.size() > 0) chk("R4 head vs model", {rd_perr, rd_ferr, rd_data}, q[0]);
            else              chk("R3 held output vs model", {rd_perr, rd_ferr, rd_data}, last_e);
            chk("R9 ovr vs model", ovr, m_ovr);
            chk("R5 irq vs model", irq, m_irq);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [10:0] e);
        wd_valid = 1'b1; {wd_perr, wd_ferr, wd_data} = e;
        @(negedge clk);
        wd_valid = 1'b0;
    endtask

    task automatic rd1();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int base;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R11: reset state
        chk("R11 avail after reset", avail, 0);
        chk("R11 ovr after reset", ovr, 0);
        chk("R11 irq after reset", irq, 0);
        chk("R11 data after reset", {rd_perr, rd_ferr, rd_data}, 0);

        // R1/R5: five words back to back, mode 00
        irq_sel = 2'b00;
        for (int i = 1; i <= 5; i++) send(w(i));
        idle(3);
        chk("R5 pulses per transfer", irq_seen, 4);
        chk("R1 no overrun with five words", ovr, 0);
        chk("R2 avail with data", avail, 1);
        chk("R4 first head", {rd_perr, rd_ferr, rd_data}, w(1));

        // R12: one read frees a slot; held word moves and is judged
        rd1();
        chk("R4 next head after pop", {rd_perr, rd_ferr, rd_data}, w(2));
        idle(2);
        chk("R12 held word transfer pulse", irq_seen, 5);
        for (int i = 3; i <= 5; i++) begin
            rd1();
            chk("R4 head sequence", {rd_perr, rd_ferr, rd_data}, w(i));
        end
        rd1();
        chk("R2 empty after drain", avail, 0);
        chk("R4 output keeps last popped", {rd_perr, rd_ferr, rd_data}, w(5));
        rd1();
        chk("R3 empty read keeps data", {rd_perr, rd_ferr, rd_data}, w(5));
        chk("R3 empty read keeps avail", avail, 0);

        // R6: mode 10 pulses only at count 3
        irq_sel = 2'b10;
        base = irq_seen;
        for (int i = 11; i <= 14; i++) begin send(w(i)); idle(1); end
        idle(3);
        chk("R6 single pulse at three", irq_seen - base, 1);
        for (int i = 0; i < 4; i++) rd1();

        // R7: mode 11 pulses only when full
        irq_sel = 2'b11;
        base = irq_seen;
        for (int i = 21; i <= 24; i++) begin send(w(i)); idle(1); end
        idle(3);
        chk("R7 single pulse at full", irq_seen - base, 1);

        // R8: held fifth word then sixth triggers overrun
        send(w(25));
        send(w(26));
        idle(2);
        chk("R8 overrun set", ovr, 1);
        send(w(27));
        for (int i = 21; i <= 24; i++) begin
            chk("R9 stored words readable", {rd_perr, rd_ferr, rd_data}, w(i));
            rd1();
        end
        idle(2);
        chk("R9 held word frozen", avail, 0);
        chk("R9 overrun still set", ovr, 1);

        // R10: clear drops held word and resumes
        ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
        idle(2);
        chk("R10 overrun cleared", ovr, 0);
        chk("R10 held word discarded", avail, 0);
        send(w(30));
        idle(2);
        chk("R10 reception resumes", {rd_perr, rd_ferr, rd_data}, w(30));
        rd1();

        // Random traffic: collisions of pop, transfer, clear and strobe
        for (int c = 0; c < 6000; c++) begin
            wd_valid = ($urandom % 3) == 0;
            {wd_perr, wd_ferr, wd_data} = 11'($urandom);
            rd_en   = ($urandom % 4) == 0;
            ovr_clr = ($urandom % 40) == 0;
            if (($urandom % 150) == 0) irq_sel = 2'($urandom);
            @(negedge clk);
        end
        wd_valid = 1'b0; rd_en = 1'b0; ovr_clr = 1'b0;
        idle(2);

        done = 1;
        summary();
        $finish;
    end

endmodule